// File: doc/BRIEF.md
# Software Interrupt Register Bank

The block is a small memory-mapped bank of inter-processor software interrupt bits, one 32-bit register per hart. Any agent on the register bus can raise the software interrupt line of a chosen hart by writing to that hart's register. Each hart has one interrupt output, and each output is driven straight from a flop.

A build-time parameter picks one of two personalities. In machine mode, each register holds a pending bit. Software can read it, set it and clear it, and reset clears it. In supervisor mode, each register is a doorbell. A write can only set the line, reads always return zero, and reset leaves the lines alone. In this mode a per-hart clear input drops the line when the target processor takes the interrupt.

The bank decodes byte offsets relative to its own base, and that base must be 4-byte aligned. Only whole-word accesses are honoured.

Top module: `swi_bank`

## Requirements
- R1: The register of hart i sits at byte offset 4*i. Only bit 0 of the write data is used, and write bits 31:1 are ignored.
- R2: A legal write with bit 0 = 1 sets the addressed hart's `swIrq` line on the clock edge that accepts the write. The line is visible from that edge on.
- R3: In machine mode, a legal write with bit 0 = 0 clears the addressed hart's line on the accepting edge.
- R4: In supervisor mode, a write with bit 0 = 0 leaves every line unchanged.
- R5: In machine mode, `busRdData` is registered. On the edge after `busRdEn` it carries the addressed hart's pending state in bit 0, with bits 31:1 zero. In every other cycle it is zero. A read that shares a cycle with a write to the same hart returns the state from before that write.
- R6: In supervisor mode, `busRdData` is always zero.
- R7: An access is illegal if its offset is 4*NUM_HARTS or above, if `busAddr[1:0]` is not zero, or if `busByteEn` is not 4'hF. An illegal write changes no line, and an illegal read returns zero.
- R8: In machine mode, an active-low `rstN` clears every line and `busRdData`.
- R9: In supervisor mode, `rstN` does not change the interrupt lines.
- R10: In supervisor mode, `extClear[i]` = 1 drops line i on the next edge. A bus set to the same hart in the same cycle wins over the clear.
- R11: In machine mode, `extClear` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the access within the bank |
| busByteEn | input | 4 | Byte enables; only 4'hF is a legal access |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid the cycle after `busRdEn` |
| extClear | input | NUM_HARTS | Per-hart clear of the doorbell line (supervisor mode) |
| swIrq | output | NUM_HARTS | Per-hart software interrupt line |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `rstN` changes away from the rising edge. They also assume that the supervisor-mode lines start from a known value, even though those lines have no reset. The stimulus meets the last point by holding every `extClear` bit high while reset is active. The stimulus drives inputs only on falling edges, and drives `rstN` one nanosecond after a falling edge. Reads and writes may share a cycle, and the stimulus deliberately does this to check which value a read returns.

// File: rtl/swi_bank_pkg.sv
`timescale 1ns/1ps
package swi_bank_pkg;

  localparam int unsigned BusDataW = 32;
  localparam int unsigned BusStrbW = BusDataW / 8;
  localparam int unsigned MaxIdxW  = 10;

  typedef enum logic {
    ModeMachine    = 1'b0,
    ModeSupervisor = 1'b1
  } swiMode_e;

  // Decoded strobes passed from control to datapath
  typedef struct packed {
    logic               setHit;
    logic               clrHit;
    logic               rdHit;
    logic [MaxIdxW-1:0] idx;
  } swiStrobe_t;

endpackage

// File: rtl/swi_ctrl.sv
`timescale 1ns/1ps
module swi_ctrl
  import swi_bank_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BusStrbW-1:0] busByteEn,
  input  logic                wrBit,
  input  logic                busWrEn,
  input  logic                busRdEn,
  output swiStrobe_t          strobe
);

  localparam int unsigned IdxW = ADDR_W - 2;
  localparam int unsigned CmpW = IdxW + 1;

  logic [IdxW-1:0] wordIdx;
  logic            aligned;
  logic            fullWord;
  logic            inRange;
  logic            legal;

  always_comb begin
    wordIdx  = busAddr[ADDR_W-1:2];
    aligned  = (busAddr[1:0] == 2'b00);
    fullWord = &busByteEn;
    inRange  = ({1'b0, wordIdx} < CmpW'(NUM_HARTS));
    legal    = aligned & fullWord & inRange;

    strobe.setHit = busWrEn & legal & wrBit;
    strobe.clrHit = busWrEn & legal & ~wrBit;
    strobe.rdHit  = busRdEn & legal;
    strobe.idx    = MaxIdxW'(wordIdx);
  end

endmodule

// File: rtl/swi_datapath.sv
`timescale 1ns/1ps
module swi_datapath
  import swi_bank_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter swiMode_e    MODE      = ModeMachine
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swiStrobe_t           strobe,
  input  logic [NUM_HARTS-1:0] extClear,
  output logic [NUM_HARTS-1:0] pendOut,
  output logic [BusDataW-1:0]  rdData
);

  logic [NUM_HARTS-1:0] hitVec;

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hit
    assign hitVec[i] = (strobe.idx == MaxIdxW'(i));
  end

  if (MODE == ModeMachine) begin : g_machine
    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_bit
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bitQ <= 1'b0;
        end else if (hitVec[i] && strobe.setHit) begin
          bitQ <= 1'b1;
        end else if (hitVec[i] && strobe.clrHit) begin
          bitQ <= 1'b0;
        end
      end
      assign pendOut[i] = bitQ;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData <= '0;
      end else begin
        rdData <= {{(BusDataW-1){1'b0}}, strobe.rdHit & (|(pendOut & hitVec))};
      end
    end

    logic unusedClear;
    assign unusedClear = ^extClear;
  end else begin : g_super
    // Doorbell lines carry no reset; the hart-side clear is their only way down
    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_bit
      logic bitQ;
      always_ff @(posedge clk) begin
        if (hitVec[i] && strobe.setHit) begin
          bitQ <= 1'b1;
        end else if (extClear[i]) begin
          bitQ <= 1'b0;
        end
      end
      assign pendOut[i] = bitQ;
    end

    assign rdData = '0;

    logic unusedSuper;
    assign unusedSuper = rstN ^ strobe.rdHit ^ strobe.clrHit;
  end

endmodule

// File: rtl/swi_bank.sv
`timescale 1ns/1ps
module swi_bank
  import swi_bank_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter swiMode_e    MODE      = ModeMachine
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [3:0]           busByteEn,
  input  logic [31:0]          busWrData,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  output logic [31:0]          busRdData,
  input  logic [NUM_HARTS-1:0] extClear,
  output logic [NUM_HARTS-1:0] swIrq
);

  swiStrobe_t strobe;

  logic unusedWrHigh;
  assign unusedWrHigh = ^busWrData[31:1];

  swi_ctrl #(
    .NUM_HARTS(NUM_HARTS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .busAddr  (busAddr),
    .busByteEn(busByteEn),
    .wrBit    (busWrData[0]),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .strobe   (strobe)
  );

  swi_datapath #(
    .NUM_HARTS(NUM_HARTS),
    .MODE     (MODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .extClear(extClear),
    .pendOut (swIrq),
    .rdData  (busRdData)
  );

endmodule

// File: rtl/swi_bank_chk.sv
`timescale 1ns/1ps
module swi_bank_chk
  import swi_bank_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter swiMode_e    MODE      = ModeMachine
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [3:0]           busByteEn,
  input logic [31:0]          busWrData,
  input logic                 busWrEn,
  input logic                 busRdEn,
  input logic [31:0]          busRdData,
  input logic [NUM_HARTS-1:0] extClear,
  input logic [NUM_HARTS-1:0] swIrq
);

  int                   tgt;
  logic                 legalAcc;
  logic [NUM_HARTS-1:0] wrSetTo;
  logic [NUM_HARTS-1:0] wrClrTo;
  logic                 rstLowQ;

  assign tgt      = int'(busAddr >> 2);
  assign legalAcc = (busByteEn == 4'hF) && (busAddr[1:0] == 2'b00) && (tgt < int'(NUM_HARTS));

  logic unusedChk;
  assign unusedChk = ^{extClear, busRdData, busWrData};

  always_ff @(posedge clk) rstLowQ <= !rstN;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign wrSetTo[h] = busWrEn && legalAcc && busWrData[0] && (tgt == h);
    assign wrClrTo[h] = busWrEn && legalAcc && !busWrData[0] && (tgt == h);

    // R2
    set_line_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrSetTo[h] |=> swIrq[h]);

    if (MODE == ModeMachine) begin : g_m
      // R3
      clear_line_chk: assert property (@(posedge clk) disable iff (!rstN)
        wrClrTo[h] |=> !swIrq[h]);
      // R11
      hold_line_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!wrSetTo[h] && !wrClrTo[h]) |=> $stable(swIrq[h]));
      // R5
      read_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
        (busRdEn && legalAcc && (tgt == h)) |=> (busRdData == {31'b0, $past(swIrq[h])}));
    end else begin : g_s
      // R4
      keep_line_chk: assert property (@(posedge clk) disable iff (!rstN)
        (swIrq[h] && !extClear[h]) |=> swIrq[h]);
      // R10
      ext_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (extClear[h] && !wrSetTo[h]) |=> !swIrq[h]);
      // R10
      set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (extClear[h] && wrSetTo[h]) |=> swIrq[h]);
    end
  end

  if (MODE == ModeMachine) begin : g_mglob
    // R7
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busRdEn && !legalAcc) |=> (busRdData == '0));
    // R5
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !busRdEn |=> (busRdData == '0));
    // R8
    always @(negedge clk) begin
      if (rstLowQ === 1'b1) begin
        reset_clear_chk: assert (swIrq == '0 && busRdData == '0);
      end
    end
  end

endmodule

bind swi_bank swi_bank_chk #(
  .NUM_HARTS(NUM_HARTS),
  .ADDR_W   (ADDR_W),
  .MODE     (MODE)
) u_chk (.*);

// File: tb/tb_swi_bank.sv
`timescale 1ns/1ps
module tb_swi_bank;
  import swi_bank_pkg::*;

  localparam int unsigned AW = 12;
  localparam int unsigned NM = 3;
  localparam int unsigned NS = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [3:0]    busByteEn = '0;
  logic [31:0]   busWrData = '0;
  logic          busWrEn = 1'b0;
  logic          busRdEn = 1'b0;
  logic [NS-1:0] extClear = '1;
  logic [31:0]   rdM, rdS;
  logic [NM-1:0] irqM;
  logic [NS-1:0] irqS;

  int compared = 0;
  int mismatched = 0;
  bit compareOn = 1'b0;
  bit done = 1'b0;

  bit [NM-1:0] mPend = '0;
  bit [NS-1:0] sPend = '0;
  bit [31:0]   mRdExp = '0;

  always #2.5 clk = ~clk;

  swi_bank #(.NUM_HARTS(NM), .ADDR_W(AW), .MODE(ModeMachine)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWrData(busWrData), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busRdData(rdM), .extClear(extClear[NM-1:0]), .swIrq(irqM));

  swi_bank #(.NUM_HARTS(NS), .ADDR_W(AW), .MODE(ModeSupervisor)) dutSup (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWrData(busWrData), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busRdData(rdS), .extClear(extClear), .swIrq(irqS));

  function automatic bit legalOf(int a, int be, int n);
    return (be == 15) && (a % 4 == 0) && (a / 4 < n);
  endfunction

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin : refModel
    int a;
    bit lm, ls;
    a  = int'(busAddr);
    lm = legalOf(a, int'(busByteEn), NM);
    ls = legalOf(a, int'(busByteEn), NS);
    if (!rstN) mRdExp = 0;
    else mRdExp = (busRdEn && lm) ? 32'(mPend[a / 4]) : 32'd0;
    if (!rstN) mPend = '0;
    else if (busWrEn && lm) mPend[a / 4] = busWrData[0];
    for (int i = 0; i < NS; i++) begin
      if (busWrEn && ls && busWrData[0] && (a / 4 == i)) sPend[i] = 1'b1;
      else if (extClear[i]) sPend[i] = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compareOn && !done) begin
      check("R2 R3 machine lines vs model", 32'(irqM), 32'(mPend));
      check("R5 machine read vs model", rdM, mRdExp);
      check("R10 supervisor lines vs model", 32'(irqS), 32'(sPend));
      check("R6 supervisor read zero", rdS, 32'd0);
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, input logic [3:0] be);
    busAddr = a; busByteEn = be; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    extClear = '0;
    compareOn = 1'b1;

    check("R8 lines after reset", 32'(irqM), 32'd0);
    check("R8 read data after reset", rdM, 32'd0);

    busWrite(12'd4, 32'd1, 4'hF);
    check("R2 machine set hart1", 32'(irqM), 32'b010);
    check("R2 supervisor set hart1", 32'(irqS), 32'b0010);

    busRead(12'd4, 4'hF);
    check("R5 machine read hart1", rdM, 32'd1);
    check("R6 supervisor read hart1", rdS, 32'd0);

    busWrite(12'd8, 32'hFFFF_FFFF, 4'hF);
    check("R1 machine hart2 at offset 8", 32'(irqM), 32'b110);
    check("R1 supervisor hart2 at offset 8", 32'(irqS), 32'b0110);

    busWrite(12'd4, 32'hFFFF_FFFE, 4'hF);
    check("R3 machine clear hart1", 32'(irqM), 32'b100);
    check("R4 supervisor zero write ignored", 32'(irqS), 32'b0110);

    busRead(12'd4, 4'hF);
    check("R5 machine read cleared hart1", rdM, 32'd0);

    busWrite(12'd1, 32'd1, 4'hF);
    check("R7 unaligned write machine", 32'(irqM), 32'b100);
    check("R7 unaligned write supervisor", 32'(irqS), 32'b0110);

    busWrite(12'd12, 32'd1, 4'hF);
    check("R7 out of range write machine", 32'(irqM), 32'b100);
    check("R2 supervisor set hart3", 32'(irqS), 32'b1110);

    busRead(12'd8, 4'h3);
    check("R7 partial read returns zero", rdM, 32'd0);
    busRead(12'd12, 4'hF);
    check("R7 out of range read returns zero", rdM, 32'd0);

    busWrite(12'd0, 32'd1, 4'h3);
    check("R7 partial write machine", 32'(irqM), 32'b100);
    check("R7 partial write supervisor", 32'(irqS), 32'b1110);

    extClear = 4'b0110;
    @(negedge clk);
    extClear = '0;
    check("R10 supervisor ext clear", 32'(irqS), 32'b1000);
    check("R11 machine ignores ext clear", 32'(irqM), 32'b100);

    busWrite(12'd4, 32'd1, 4'hF);
    busAddr = 12'd8; busWrData = 32'd1; busByteEn = 4'hF; busWrEn = 1'b1;
    extClear = 4'b1110;
    @(negedge clk);
    busWrEn = 1'b0;
    extClear = '0;
    check("R10 set beats clear", 32'(irqS), 32'b0100);

    busAddr = 12'd0; busWrData = 32'd1; busByteEn = 4'hF;
    busWrEn = 1'b1; busRdEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    check("R5 read sees pre-write state", rdM, 32'd0);
    check("R2 machine set hart0", 32'(irqM), 32'b111);
    check("R2 supervisor set hart0", 32'(irqS), 32'b0101);

    #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 machine reset clears", 32'(irqM), 32'd0);
    check("R9 supervisor reset keeps lines", 32'(irqS), 32'b0101);
    #1 rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 600; k++) begin
      busAddr   = AW'($urandom_range(0, 20));
      busByteEn = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      busWrData = $urandom;
      busWrEn   = 1'($urandom_range(0, 1));
      busRdEn   = 1'($urandom_range(0, 1));
      extClear  = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
      @(negedge clk);
    end
    busWrEn = 1'b0; busRdEn = 1'b0; extClear = '0;
    @(negedge clk);

    finishRun();
  end

endmodule